// File: doc/BRIEF.md
# Tracking Counter ADC Controller

This block is the digital half of a tracking analogue-to-digital converter. It drives a binary code into an external DAC. An external comparator reports, once per clock, whether the analogue input lies above the DAC output. Each clock the controller moves the code by exactly one LSB toward the input. When the code starts to dither around the input, or meets a rail, the conversion has settled. The controller then captures a result and raises a valid flag.

The code is never cleared between samples. A new conversion starts from wherever the previous one left the code, so its length grows with the distance the input has moved since the last sample. A slowly varying input therefore converts in a few clocks. The comparator is treated as reporting "input strictly above code". Under that reading the captured result is the largest code that lies below the input, or zero when no code does.

The control is a four-state machine:
- `ST_IDLE`: after reset, waiting for the first strobe.
- `ST_FIRST`: the first step of a conversion, when no earlier direction exists.
- `ST_TRACK`: stepping and watching for a direction reversal.
- `ST_HOLD`: settled, with result and code frozen.

The transitions are:
- strobe: from any state to `ST_FIRST`.
- step: `ST_FIRST` to `ST_TRACK`, or `ST_TRACK` staying in `ST_TRACK`.
- settle: `ST_FIRST` or `ST_TRACK` to `ST_HOLD`.
- wait: `ST_IDLE` or `ST_HOLD` stays where it is.

Top module: `track_adc_ctrl`

## Requirements
- R1: A clock edge with `rst` high sets `dac_code` and `conv_result` to 0 and `conv_valid` to 0, and returns the machine to `ST_IDLE`.
- R2: While a conversion runs and has not settled, each clock changes `dac_code` by exactly one LSB: up when `cmp_above` is 1, down when it is 0.
- R3: `dac_code` saturates at 0 and at 2^W-1 and never wraps from one end to the other.
- R4: A conversion settles when the comparator direction reverses between two consecutive clocks, or when it pushes against a rail. It also settles on its first clock if that clock already pushes against a rail. The clock edge at which it settles raises `conv_valid`.
- R5: On settling, `conv_result` takes the lower code of the dithering pair. That is the code itself after a down-to-up reversal or a rail, and the code minus one after an up-to-down reversal. With a comparator meaning "input above code", this gives the largest code below the input, clamped to 0..2^W-1.
- R6: While `conv_valid` is 1 and no strobe arrives, `conv_result`, `dac_code` and `conv_valid` stay unchanged whatever `cmp_above` does.
- R7: The edge that samples `sample_stb` high clears `conv_valid` and leaves `dac_code` unchanged. A strobe during a running conversion restarts it from the current code.
- R8: Let c0 be the code when the strobe is sampled and T the expected result. `conv_valid` rises this many edges after the strobe edge:
  - T - c0 + 2 when c0 <= T and the top rail is not reached;
  - c0 - T + 1 when c0 > T;
  - 2^W - c0 when the input lies above the top code;
  - c0 + 1 when the input lies at or below code 0.
- R9: A conversion starts from the code the previous conversion left: the upper code of the pair after an up-to-down reversal, otherwise the result code.
- R10: In `ST_IDLE` the code does not move, whatever `cmp_above` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one comparator decision per edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Starts (or restarts) a conversion |
| cmp_above | input | 1 | Comparator: 1 when the input is above the DAC output |
| dac_code | output | W | Code driving the feedback DAC |
| conv_result | output | W | Latched result of the last settled conversion |
| conv_valid | output | 1 | High while `conv_result` holds a settled conversion |

## Verification
Every output is registered. `conv_valid` therefore drops one edge after the strobe edge, and `dac_code` moves one edge after each comparator decision. `conv_valid` and `conv_result` appear together on the edge R8 predicts from the starting code and the input. The bench drives the strobe on a falling edge and counts falling edges from the strobe edge. It compares that count with the R8 latency computed from its own model of the input. It also checks at each intermediate falling edge that the code moved one LSB in the comparator's direction. Hold and idle behaviour is checked by changing the modelled input for several cycles and confirming that the ports stay still.

// File: rtl/tadc_pkg.sv
package tadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_TRACK = 2'd2,
        ST_HOLD  = 2'd3
    } tadc_state_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } tadc_dir_e;

endpackage

// File: rtl/tadc_updown.sv
// Saturating up/down code register; one LSB per enabled clock.
module tadc_updown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic         dir_up,
    output logic [W-1:0] code,
    output logic         at_top,
    output logic         at_bottom
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = {W{1'b0}};

    assign at_top    = (code == TOP);
    assign at_bottom = (code == BOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= BOT;
        end else if (step_en) begin
            if (dir_up && !at_top) begin
                code <= code + 1'b1;
            end else if (!dir_up && !at_bottom) begin
                code <= code - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tadc_dither.sv
// Settle detection: direction reversal or rail contact; picks the lower code.
module tadc_dither #(
    parameter int W = 8
) (
    input  logic         have_prev,
    input  logic         dir_now,
    input  logic         dir_prev,
    input  logic [W-1:0] code,
    input  logic         at_top,
    input  logic         at_bottom,
    output logic         settle,
    output logic [W-1:0] settle_code
);
    logic reversed;
    logic rail_hit;
    logic fell_back;

    always_comb begin
        reversed  = have_prev && (dir_now != dir_prev);
        rail_hit  = (dir_now && at_top) || (!dir_now && at_bottom);
        settle    = reversed || rail_hit;
        // up-then-down reversal: the code sits one above the lower pair member
        fell_back = reversed && !dir_now;
        settle_code = fell_back ? (code - 1'b1) : code;
    end
endmodule

// File: rtl/tadc_fsm.sv
// Conversion sequencer: state register, next-state and output decode.
module tadc_fsm
    import tadc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_stb,
    input  logic        cmp_above,
    input  logic        settle,
    output logic        have_prev,
    output logic        dir_prev,
    output logic        step_en,
    output logic        latch_en,
    output logic        clr_valid
);
    tadc_state_e state_q;
    tadc_state_e state_d;
    logic        running;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sample_stb) state_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (sample_stb)  state_d = ST_FIRST;
                else if (settle) state_d = ST_HOLD;
                else             state_d = ST_TRACK;
            end
            ST_TRACK: begin
                if (sample_stb)  state_d = ST_FIRST;
                else if (settle) state_d = ST_HOLD;
                else             state_d = ST_TRACK;
            end
            ST_HOLD: begin
                if (sample_stb) state_d = ST_FIRST;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running   = 1'b0;
        have_prev = 1'b0;
        unique case (state_q)
            ST_IDLE:  running = 1'b0;
            ST_FIRST: running = 1'b1;
            ST_TRACK: begin
                running   = 1'b1;
                have_prev = 1'b1;
            end
            ST_HOLD:  running = 1'b0;
            default:  running = 1'b0;
        endcase
        step_en   = running && !sample_stb && !settle;
        latch_en  = running && !sample_stb && settle;
        clr_valid = sample_stb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_prev <= DIR_DOWN;
        end else if (step_en) begin
            dir_prev <= cmp_above;
        end
    end
endmodule

// File: rtl/track_adc_ctrl.sv
module track_adc_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample_stb,
    input  logic         cmp_above,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] conv_result,
    output logic         conv_valid
);
    logic         step_en;
    logic         latch_en;
    logic         clr_valid;
    logic         have_prev;
    logic         dir_prev;
    logic         settle;
    logic [W-1:0] settle_code;
    logic         at_top;
    logic         at_bottom;

    tadc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sample_stb (sample_stb),
        .cmp_above  (cmp_above),
        .settle     (settle),
        .have_prev  (have_prev),
        .dir_prev   (dir_prev),
        .step_en    (step_en),
        .latch_en   (latch_en),
        .clr_valid  (clr_valid)
    );

    tadc_updown #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .dir_up    (cmp_above),
        .code      (dac_code),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    tadc_dither #(.W(W)) u_dith (
        .have_prev   (have_prev),
        .dir_now     (cmp_above),
        .dir_prev    (dir_prev),
        .code        (dac_code),
        .at_top      (at_top),
        .at_bottom   (at_bottom),
        .settle      (settle),
        .settle_code (settle_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_result <= '0;
            conv_valid  <= 1'b0;
        end else begin
            if (latch_en) begin
                conv_result <= settle_code;
            end
            if (clr_valid) begin
                conv_valid <= 1'b0;
            end else if (latch_en) begin
                conv_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tadc_checker.sv
module tadc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         sample_stb,
    input logic         cmp_above,
    input logic [W-1:0] dac_code,
    input logic [W-1:0] conv_result,
    input logic         conv_valid
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = {W{1'b0}};

    logic seen_rst;
    logic armed;
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            seen_rst <= 1'b1;
        end else if (seen_rst !== 1'b1) begin
            seen_rst <= 1'b0;
        end
        armed <= (seen_rst === 1'b1) && !rst;
    end

    // R1: one edge after a reset edge the outputs show the cleared values
    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            assert_reset_clear_R1: assert (dac_code == BOT && conv_result == BOT && !conv_valid)
                else $error("reset did not clear outputs");
        end
    end

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        ($past(cmp_above) && (dac_code != $past(dac_code))) |-> (dac_code == $past(dac_code) + 1'b1));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (!$past(cmp_above) && (dac_code != $past(dac_code))) |-> (dac_code == $past(dac_code) - 1'b1));

    assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        ($past(dac_code) == TOP) |-> (dac_code != BOT));

    assert_no_wrap_bot_R3: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        ($past(dac_code) == BOT) |-> (dac_code != TOP));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (conv_valid && !sample_stb) |=> ($stable(conv_result) && $stable(dac_code) && conv_valid));

    assert_strobe_clears_R7: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        sample_stb |=> (!conv_valid && $stable(dac_code)));

endmodule

bind track_adc_ctrl tadc_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_stb  (sample_stb),
    .cmp_above   (cmp_above),
    .dac_code    (dac_code),
    .conv_result (conv_result),
    .conv_valid  (conv_valid)
);

// File: tb/track_adc_ctrl_tb.sv
module track_adc_ctrl_tb;
    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sample_stb = 1'b0;
    logic         cmp_above;
    logic [W-1:0] dac_code;
    logic [W-1:0] conv_result;
    logic         conv_valid;

    int ain = 0;
    int n_tests = 0;
    int n_fail = 0;
    int exp_code = 0;
    bit done = 0;

    // behavioural comparator + DAC: input strictly above the DAC level
    assign cmp_above = (ain > int'(dac_code));

    always #(CLK_PERIOD/2) clk = ~clk;

    track_adc_ctrl #(.W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .sample_stb  (sample_stb),
        .cmp_above   (cmp_above),
        .dac_code    (dac_code),
        .conv_result (conv_result),
        .conv_valid  (conv_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(dac_code == 0, "R1", "code after reset", int'(dac_code), 0);
        check(conv_result == 0, "R1", "result after reset", int'(conv_result), 0);
        check(conv_valid == 0, "R1", "valid after reset", int'(conv_valid), 0);
        exp_code = 0;
    endtask

    task automatic t_idle();
        ain = 120;
        for (int i = 0; i < 6; i++) @(negedge clk);
        check(dac_code == 0, "R10", "idle code with comparator high", int'(dac_code), 0);
        check(conv_valid == 0, "R10", "idle valid", int'(conv_valid), 0);
    endtask

    // one strobed conversion; expected values follow R5/R8/R9
    task automatic t_convert(input int a, input bit chk_prev);
        int c0, t, lat, ecode, n, prev;
        bit step_ok;
        @(negedge clk);
        c0 = int'(dac_code);
        if (chk_prev)
            check(c0 == exp_code, "R9", "start code kept from last sample", c0, exp_code);
        ain = a;
        if (a > MAXC) begin
            t = MAXC; lat = MAXC - c0 + 1; ecode = MAXC;
        end else if (a <= 0) begin
            t = 0; lat = c0 + 1; ecode = 0;
        end else begin
            t = a - 1;
            if (c0 <= t) begin lat = t - c0 + 2; ecode = t + 1; end
            else         begin lat = c0 - t + 1; ecode = t;     end
        end
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        check(conv_valid == 0, "R7", "valid after strobe", int'(conv_valid), 0);
        check(int'(dac_code) == c0, "R7", "code on strobe edge", int'(dac_code), c0);
        prev = c0;
        step_ok = 1'b1;
        n = 0;
        for (int i = 1; i <= 600; i++) begin
            @(negedge clk);
            n = i;
            if (conv_valid) break;
            if (int'(dac_code) != ((prev < a) ? prev + 1 : prev - 1)) step_ok = 1'b0;
            prev = int'(dac_code);
        end
        check(step_ok, "R2", "one LSB step toward input each clock", prev, a);
        check(n == lat, "R8", "settle latency", n, lat);
        check(conv_valid == 1, "R4", "valid after settle", int'(conv_valid), 1);
        check(int'(conv_result) == t, "R5", "latched result", int'(conv_result), t);
        exp_code = ecode;
    endtask

    task automatic t_hold();
        int r, c;
        r = int'(conv_result);
        c = int'(dac_code);
        for (int i = 0; i < 4; i++) begin
            ain = (i % 2 == 0) ? 0 : MAXC + 1;
            @(negedge clk);
        end
        check(int'(conv_result) == r, "R6", "result held", int'(conv_result), r);
        check(int'(dac_code) == c, "R6", "code held", int'(dac_code), c);
        check(conv_valid == 1, "R6", "valid held", int'(conv_valid), 1);
    endtask

    task automatic t_rails();
        t_convert(MAXC + 40, 1'b1);
        check(int'(dac_code) == MAXC, "R3", "code saturates at top", int'(dac_code), MAXC);
        t_convert(MAXC + 40, 1'b1);
        check(int'(dac_code) == MAXC, "R3", "no wrap from top", int'(dac_code), MAXC);
        t_convert(0, 1'b1);
        check(int'(dac_code) == 0, "R3", "code saturates at bottom", int'(dac_code), 0);
        t_convert(0, 1'b1);
        check(int'(dac_code) == 0, "R3", "no wrap from bottom", int'(dac_code), 0);
    endtask

    task automatic t_restart();
        @(negedge clk);
        ain = 200;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        for (int i = 0; i < 5; i++) @(negedge clk);
        check(conv_valid == 0, "R7", "valid low while tracking", int'(conv_valid), 0);
        t_convert(40, 1'b0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        ain = 150;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        t_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_convert(100, 1'b1);
        t_hold();
        t_convert(100, 1'b1);
        t_convert(90, 1'b1);
        t_rails();
        t_convert(1, 1'b1);
        t_restart();
        t_hold();
        t_reset_mid();
        t_convert(7, 1'b1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule